// File: doc/BRIEF.md
# Three-Port Parallel I/O Register File

This block holds the programmable state of a three-port, byte-wide parallel I/O controller. A host CPU reaches it through a small bus: an active-low select, a two-bit address, and active-low read and write strobes. Through that bus the CPU can load a configuration word, set or clear any single bit of the third port, write the three port output latches and read back either the port contents or the configuration word. The register file turns the configuration word into per-port direction flags and per-group mode codes. The handshake logic placed above it consumes those flags and codes. The block does not implement any strobed or bidirectional handshake timing itself.

The bus is sampled synchronously. Every rising clock edge at which select and write are both low performs one write. A read is combinational: the data output shows the addressed value for as long as select and read are low, and it is zero at all other times. Port C is split into two nibbles, and each nibble has its own direction. Configuration words and single-bit words share the control address and are told apart by bit 7 of the written byte.

Top module: `ppi_regfile`

## Requirements
- R1: While reset is low at a clock edge, the block returns to this state: the control word is 9Bh, all four direction outputs are 1 (input), both group modes are 0, and all three port output latches are zero.
- R2: A write to address 11 with bit 7 set stores the whole byte as the control word, and a later read of address 11 returns that byte.
- R3: The group A mode output is 0 when control bits 6:5 are 00, 1 when they are 01, and 2 when bit 6 is 1. The group B mode output equals control bit 2.
- R4: Each direction output reads 1 for input and 0 for output, taken from control bit 4 (port A), bit 3 (port C upper nibble), bit 1 (port B) and bit 0 (port C lower nibble).
- R5: Every configuration-word write clears all three port output latches to zero in the same edge.
- R6: A write to address 11 with bit 7 clear sets bit number din[3:1] of the port C latch to din[0]. The other latch bits and the stored control word are not changed.
- R7: A write to address 00, 01 or 10 loads the byte into the port A, B or C output latch, and only that latch changes.
- R8: While select is high, writes do not change any state and the data output is zero.
- R9: A read of a port returns the input pins for each bit whose direction is input, and the output latch for each bit whose direction is output. Port C is resolved per nibble.
- R10: The data output is zero whenever read is high.
- R11: When read and write are both active in one cycle, the data output shows the value held before the edge, and the written value becomes visible on the data output after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Bus select, active low |
| addr_i | input | 2 | Target: 00 A, 01 B, 10 C, 11 control |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din_i | input | 8 | Write data |
| dout_o | output | 8 | Read data, zero when no read is active |
| pa_pins_i | input | 8 | Port A pin values |
| pb_pins_i | input | 8 | Port B pin values |
| pc_pins_i | input | 8 | Port C pin values |
| pa_lat_o | output | 8 | Port A output latch |
| pb_lat_o | output | 8 | Port B output latch |
| pc_lat_o | output | 8 | Port C output latch |
| pa_dir_in_o | output | 1 | Port A is input |
| pb_dir_in_o | output | 1 | Port B is input |
| pcu_dir_in_o | output | 1 | Port C bits 7:4 are input |
| pcl_dir_in_o | output | 1 | Port C bits 3:0 are input |
| grp_a_mode_o | output | 2 | Group A mode 0, 1 or 2 |
| grp_b_mode_o | output | 1 | Group B mode 0 or 1 |

## Verification
A read and a write can land in the same cycle. The bench provokes this by holding both strobes low on the control address while the control word is 98h and writing 9Bh. It samples the data output just after the falling edge, where the old word is expected. It samples again after the following rising edge, where the new word is expected, since the read is still held. A second overlap is a configuration write that lands on latches holding data: the bench loads all three latches and then rewrites the configuration word, and every latch must read zero after that edge.

// File: rtl/ppi_pkg.sv
// Shared definitions for the parallel I/O register file.
// Assumes an 8-bit data path; the address map and mode codes are fixed.
package ppi_pkg;
    localparam int PORT_CNT = 3;

    typedef enum logic [1:0] {
        SEL_A    = 2'b00,
        SEL_B    = 2'b01,
        SEL_C    = 2'b10,
        SEL_CTRL = 2'b11
    } ppi_sel_e;

    typedef enum logic [1:0] {
        GMODE_BASIC   = 2'd0,
        GMODE_STROBED = 2'd1,
        GMODE_BIDIR   = 2'd2
    } ppi_gmode_e;
endpackage

// File: rtl/ppi_bus_decode.sv
// Turns bus select/address/strobes into one-cycle write enables.
// Assumes the strobes are synchronous to clk; every low-write cycle is one write.
module ppi_bus_decode
    import ppi_pkg::*;
#(
    parameter int NPORT = PORT_CNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic [1:0]       addr,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             din_msb,
    output logic             mode_we,
    output logic             bit_we,
    output logic [NPORT-1:0] port_we,
    output logic             rd_en
);
    logic wr_en;

    // Qualify strobes with select.
    always_comb begin
        wr_en = !cs_n && !wr_n;
        rd_en = !cs_n && !rd_n;
    end

    // Control address: bit 7 of data picks configuration or single-bit word.
    always_comb begin
        mode_we = wr_en && (addr == SEL_CTRL) && din_msb;
        bit_we  = wr_en && (addr == SEL_CTRL) && !din_msb;
    end

    // One data-latch enable per port address.
    for (genvar gi = 0; gi < NPORT; gi++) begin : g_port_we
        assign port_we[gi] = wr_en && (addr == 2'(gi));
    end

    p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mode_we, bit_we, port_we}));

    p_cs_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !(mode_we || bit_we || (|port_we) || rd_en));
endmodule

// File: rtl/ppi_ctrl_reg.sv
// Holds the configuration word and decodes directions and group modes.
// Assumes mode_we is only raised for words with bit 7 set.
module ppi_ctrl_reg
    import ppi_pkg::*;
#(
    parameter int         W        = 8,
    parameter logic [W-1:0] RST_WORD = 8'h9B
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ctrl_q,
    output logic [1:0]   a_mode,
    output logic         b_mode,
    output logic         pa_in,
    output logic         pb_in,
    output logic         pcu_in,
    output logic         pcl_in
);
    // Store the configuration word; reset loads the all-input default.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= RST_WORD;
        else if (mode_we) ctrl_q <= wdata;
    end

    // Decode mode fields and direction flags from the stored word.
    always_comb begin
        if (ctrl_q[6])      a_mode = GMODE_BIDIR;
        else if (ctrl_q[5]) a_mode = GMODE_STROBED;
        else                a_mode = GMODE_BASIC;
        b_mode = ctrl_q[2];
        pa_in  = ctrl_q[4];
        pcu_in = ctrl_q[3];
        pb_in  = ctrl_q[1];
        pcl_in = ctrl_q[0];
    end

    p_reset_word_r1: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == RST_WORD));

    p_load_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (ctrl_q == $past(wdata)));

    p_hold_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we |=> $stable(ctrl_q));

    p_mode_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        a_mode != 2'd3);
endmodule

// File: rtl/ppi_port_latches.sv
// Output latches for ports A, B and C with clear-on-configure and
// single-bit update of port C. Assumes at most one enable per cycle.
module ppi_port_latches
    import ppi_pkg::*;
#(
    parameter int W     = 8,
    parameter int NPORT = PORT_CNT,
    parameter int PC_IX = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mode_we,
    input  logic                      bit_we,
    input  logic [NPORT-1:0]          port_we,
    input  logic [W-1:0]              wdata,
    output logic [NPORT-1:0][W-1:0]   lat_q
);
    localparam int IDX_W = $clog2(W);

    logic [IDX_W-1:0] bit_idx;
    logic             bit_val;

    // Extract the bit index and value of a single-bit word.
    always_comb begin
        bit_idx = wdata[IDX_W:1];
        bit_val = wdata[0];
    end

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_lat
        // Per-port latch: reset and configuration clear, then byte or bit load.
        always_ff @(posedge clk) begin
            if (!rst_n || mode_we)
                lat_q[gi] <= '0;
            else if (port_we[gi])
                lat_q[gi] <= wdata;
            else if ((gi == PC_IX) && bit_we)
                lat_q[gi][bit_idx] <= bit_val;
        end
    end

    p_clear_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (lat_q == '0));

    p_bit_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_we |=> (((lat_q[PC_IX] ^ $past(lat_q[PC_IX]))
                     & ~(W'(1) << $past(bit_idx))) == '0));

    p_bit_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_we |=> (lat_q[PC_IX][$past(bit_idx)] == $past(bit_val)));
endmodule

// File: rtl/ppi_read_mux.sv
// Builds the read view of each port (pins where input, latch where
// output) and selects the addressed value. Zero when no read is active.
module ppi_read_mux
    import ppi_pkg::*;
#(
    parameter int W     = 8,
    parameter int NPORT = PORT_CNT
) (
    input  logic                    rd_en,
    input  logic [1:0]              addr,
    input  logic [W-1:0]            ctrl_q,
    input  logic [NPORT-1:0][W-1:0] lat,
    input  logic [NPORT-1:0][W-1:0] pins,
    input  logic [NPORT-1:0][W-1:0] in_mask,
    output logic [W-1:0]            dout
);
    logic [NPORT-1:0][W-1:0] view;

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_view
        assign view[gi] = (pins[gi] & in_mask[gi]) | (lat[gi] & ~in_mask[gi]);
    end

    // Select the addressed source during an active read.
    always_comb begin
        dout = '0;
        if (rd_en) begin
            if (addr == SEL_CTRL) dout = ctrl_q;
            else                  dout = view[addr];
        end
    end
endmodule

// File: rtl/ppi_regfile.sv
// Register file of a three-port parallel I/O controller: bus decode,
// configuration word, port latches and read-back. Handshake timing is
// provided by the logic that consumes the direction and mode outputs.
module ppi_regfile
    import ppi_pkg::*;
#(
    parameter int           W        = 8,
    parameter logic [W-1:0] RST_WORD = 8'h9B
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic [1:0]   addr_i,
    input  logic         rd_n,
    input  logic         wr_n,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o,
    input  logic [W-1:0] pa_pins_i,
    input  logic [W-1:0] pb_pins_i,
    input  logic [W-1:0] pc_pins_i,
    output logic [W-1:0] pa_lat_o,
    output logic [W-1:0] pb_lat_o,
    output logic [W-1:0] pc_lat_o,
    output logic         pa_dir_in_o,
    output logic         pb_dir_in_o,
    output logic         pcu_dir_in_o,
    output logic         pcl_dir_in_o,
    output logic [1:0]   grp_a_mode_o,
    output logic         grp_b_mode_o
);
    localparam int NPORT = PORT_CNT;
    localparam int HALF  = W / 2;

    logic                    mode_we, bit_we, rd_en;
    logic [NPORT-1:0]        port_we;
    logic [W-1:0]            ctrl_q;
    logic [NPORT-1:0][W-1:0] lat_q, pins, in_mask;

    ppi_bus_decode #(.NPORT(NPORT)) u_dec (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr_i),
        .wr_n(wr_n), .rd_n(rd_n), .din_msb(din_i[W-1]),
        .mode_we(mode_we), .bit_we(bit_we), .port_we(port_we), .rd_en(rd_en)
    );

    ppi_ctrl_reg #(.W(W), .RST_WORD(RST_WORD)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .wdata(din_i),
        .ctrl_q(ctrl_q), .a_mode(grp_a_mode_o), .b_mode(grp_b_mode_o),
        .pa_in(pa_dir_in_o), .pb_in(pb_dir_in_o),
        .pcu_in(pcu_dir_in_o), .pcl_in(pcl_dir_in_o)
    );

    ppi_port_latches #(.W(W), .NPORT(NPORT), .PC_IX(2)) u_lat (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .bit_we(bit_we),
        .port_we(port_we), .wdata(din_i), .lat_q(lat_q)
    );

    // Gather pins and per-bit input masks for the read view.
    always_comb begin
        pins[0]    = pa_pins_i;
        pins[1]    = pb_pins_i;
        pins[2]    = pc_pins_i;
        in_mask[0] = {W{pa_dir_in_o}};
        in_mask[1] = {W{pb_dir_in_o}};
        in_mask[2] = {{HALF{pcu_dir_in_o}}, {(W - HALF){pcl_dir_in_o}}};
    end

    ppi_read_mux #(.W(W), .NPORT(NPORT)) u_rd (
        .rd_en(rd_en), .addr(addr_i), .ctrl_q(ctrl_q), .lat(lat_q),
        .pins(pins), .in_mask(in_mask), .dout(dout_o)
    );

    // Expose latches on the port outputs.
    always_comb begin
        pa_lat_o = lat_q[0];
        pb_lat_o = lat_q[1];
        pc_lat_o = lat_q[2];
    end

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> (dout_o == '0));

    p_no_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(ctrl_q) && $stable(pa_lat_o)
                  && $stable(pb_lat_o) && $stable(pc_lat_o)));

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (pa_dir_in_o && pb_dir_in_o && pcu_dir_in_o && pcl_dir_in_o
                    && lat_q == '0));
endmodule

// File: tb/ppi_regfile_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module ppi_regfile_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'b00;
    logic [7:0] din = 8'h00;
    logic [7:0] pa_pins = 8'h00, pb_pins = 8'h00, pc_pins = 8'h00;
    logic [7:0] dout, pa_lat, pb_lat, pc_lat;
    logic       pa_in, pb_in, pcu_in, pcl_in, b_mode;
    logic [1:0] a_mode;
    int         n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    ppi_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr_i(addr), .rd_n(rd_n),
        .wr_n(wr_n), .din_i(din), .dout_o(dout), .pa_pins_i(pa_pins),
        .pb_pins_i(pb_pins), .pc_pins_i(pc_pins), .pa_lat_o(pa_lat),
        .pb_lat_o(pb_lat), .pc_lat_o(pc_lat), .pa_dir_in_o(pa_in),
        .pb_dir_in_o(pb_in), .pcu_dir_in_o(pcu_in), .pcl_dir_in_o(pcl_in),
        .grp_a_mode_o(a_mode), .grp_b_mode_o(b_mode)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1 d = dout;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bus_read(2'b11, v);
        chk("R1 ctrl", v, 8'h9B);
        chk("R1 dirs", {4'h0, pa_in, pb_in, pcu_in, pcl_in}, 8'h0F);
        chk("R1 modes", {5'h0, a_mode, b_mode}, 8'h00);
        chk("R1 latches", pa_lat | pb_lat | pc_lat, 8'h00);
    endtask

    task automatic t_mode_word();
        logic [7:0] v;
        bus_write(2'b11, 8'hC5);
        bus_read(2'b11, v);
        chk("R2 readback", v, 8'hC5);
        chk("R3 a mode2", {6'h0, a_mode}, 8'h02);
        chk("R3 b mode1", {7'h0, b_mode}, 8'h01);
        chk("R4 dirs C5", {4'h0, pa_in, pb_in, pcu_in, pcl_in}, 8'h01);
        bus_write(2'b11, 8'hA0);
        chk("R3 a mode1", {6'h0, a_mode}, 8'h01);
        chk("R3 b mode0", {7'h0, b_mode}, 8'h00);
        bus_write(2'b11, 8'h9A);
        chk("R4 dirs 9A", {4'h0, pa_in, pb_in, pcu_in, pcl_in}, 8'h0E);
        chk("R3 a mode0", {6'h0, a_mode}, 8'h00);
    endtask

    task automatic t_latch_clear();
        bus_write(2'b11, 8'h80);
        bus_write(2'b00, 8'h5A);
        chk("R7 port A", pa_lat, 8'h5A);
        chk("R7 B untouched", pb_lat, 8'h00);
        bus_write(2'b01, 8'hA5);
        bus_write(2'b10, 8'h3C);
        chk("R7 port B", pb_lat, 8'hA5);
        chk("R7 port C", pc_lat, 8'h3C);
        bus_write(2'b11, 8'h80);
        chk("R5 clear", pa_lat | pb_lat | pc_lat, 8'h00);
    endtask

    task automatic t_bit_ops();
        logic [7:0] v;
        bus_write(2'b11, 8'h80);
        bus_write(2'b11, 8'h0F);
        chk("R6 set bit7", pc_lat, 8'h80);
        bus_write(2'b11, 8'h05);
        chk("R6 set bit2", pc_lat, 8'h84);
        bus_write(2'b11, 8'h0E);
        chk("R6 clear bit7", pc_lat, 8'h04);
        bus_read(2'b11, v);
        chk("R6 ctrl kept", v, 8'h80);
        chk("R6 A kept", pa_lat, 8'h00);
    endtask

    task automatic t_no_select();
        logic [7:0] v;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'b00; din = 8'hFF;
        @(negedge clk);
        wr_n = 1'b0; addr = 2'b11; din = 8'h9B;
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b0;
        #1 v = dout;
        rd_n = 1'b1;
        chk("R8 dout zero", v, 8'h00);
        chk("R8 A kept", pa_lat, 8'h00);
        bus_read(2'b11, v);
        chk("R8 ctrl kept", v, 8'h80);
    endtask

    task automatic t_read_view();
        logic [7:0] v;
        bus_write(2'b11, 8'h98);
        bus_write(2'b01, 8'h33);
        bus_write(2'b10, 8'h5A);
        bus_write(2'b00, 8'h11);
        pa_pins = 8'hC3; pb_pins = 8'hF0; pc_pins = 8'hE7;
        bus_read(2'b00, v);
        chk("R9 A pins", v, 8'hC3);
        bus_read(2'b01, v);
        chk("R9 B latch", v, 8'h33);
        bus_read(2'b10, v);
        chk("R9 C split", v, 8'hEA);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b1; addr = 2'b00;
        #1 chk("R10 idle zero", dout, 8'h00);
        cs_n = 1'b1;
    endtask

    task automatic t_overlap();
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; addr = 2'b11; din = 8'h9B;
        #1 chk("R11 old word", dout, 8'h98);
        @(posedge clk);
        #1 chk("R11 new word", dout, 8'h9B);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        chk("R11 latch cleared", pb_lat | pc_lat, 8'h00);
    endtask

    task automatic t_reset_again();
        logic [7:0] v;
        bus_write(2'b11, 8'h80);
        bus_write(2'b00, 8'h77);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        bus_read(2'b11, v);
        chk("R1 reapply ctrl", v, 8'h9B);
        chk("R1 reapply latch", pa_lat, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mode_word();
        t_latch_clear();
        t_bit_ops();
        t_no_select();
        t_read_view();
        t_overlap();
        t_reset_again();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule